// File: doc/BRIEF.md
# Network Status LED Driver

This block turns the link, speed, duplex, activity and collision indications of a 10/100 Ethernet port into three LED drive signals. A one-bit configuration input chooses what the first two pins mean. In the first pin mapping they show speed, and duplex or collision. In the second pin mapping they show 100 Mb/s link and 10 Mb/s link. The third pin always shows traffic.

Blinking is timed from the reference clock by a prescaler. The prescaler makes a fast square wave at `BLINK_HZ`, nominally 20 Hz, and a slow square wave at half that rate, nominally 10 Hz. Both have 50% duty. Activity and collision indications are single-cycle event strobes. Each strobe is stretched so that even one short frame gives a blink that can be seen. All three LED outputs are registered and are active-high. Polarity and board drive are handled outside the block.

Top module: `led_status_top`

## Requirements
- R1: While `rst_n` is low, all three LED outputs are 0. They stay 0 until the two-stage reset synchronizer has released the internal logic, which is the third rising clock edge after `rst_n` rises.
- R2: The fast wave toggles every HALF = `REF_HZ/(2*BLINK_HZ)` clock cycles and starts at 0 when reset is released. The slow wave toggles each time the fast wave falls, so its half period is 2*HALF cycles. Both waves have 50% duty.
- R3: While activity is active, `led_act` follows the slow wave. Otherwise `led_act` is 0. The `act_evt` input does not depend on the link.
- R4: Activity stays active for 4*HALF cycles after the cycle of the last `act_evt`, which is one full slow period. Collision stays active for 2*HALF cycles after the last `coll_evt`, which is one full fast period.
- R5: `led_speed` is 1 exactly when `link_up` and `speed_100` were both 1 on the previous clock edge. This holds in both pin mappings.
- R6: With `pin_mode` = 0 and no collision active, `led_aux` is steadily on when the link is up in full duplex (`link_up`=1, `full_dup`=1). Otherwise it is off.
- R7: With `pin_mode` = 0, while a collision is active, `led_aux` follows the fast wave. Collision takes precedence over full duplex.
- R8: With `pin_mode` = 1, `led_aux` is steadily on exactly when the link is up at 10 Mb/s (`link_up`=1, `speed_100`=0), and `led_speed` shows the 100 Mb/s link.
- R9: With `pin_mode` = 1, `full_dup` and `coll_evt` have no effect on `led_aux`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominally 25 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_mode | input | 1 | 0: speed/duplex-collision mapping; 1: 100M-link/10M-link mapping |
| link_up | input | 1 | Link established |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dup | input | 1 | Full-duplex operation |
| act_evt | input | 1 | One-cycle strobe per transmit or receive event |
| coll_evt | input | 1 | One-cycle strobe per collision |
| led_speed | output | 1 | Speed LED (mapping 0) / 100 Mb/s link LED (mapping 1) |
| led_aux | output | 1 | Duplex-collision LED (mapping 0) / 10 Mb/s link LED (mapping 1) |
| led_act | output | 1 | Activity LED |

## Verification
The bench builds the block with `REF_HZ`=80 and `BLINK_HZ`=10. That gives HALF=4, a fast period of 8 cycles, a slow period of 16 cycles, and stretch windows of 16 and 8 cycles. With these values many blink periods, stretch expiries and stretch re-triggers fit in a few thousand cycles. Sparse random event strobes land at every phase of both waves. This brings the boundary of the stretch window into reach, along with collision-over-duplex precedence and the mapping change. A reset in the middle of the run checks that the prescaler phase and stretch state restart cleanly.

// File: rtl/led_pkg.sv
package led_pkg;
  typedef enum logic {
    MAP_SPEED_DUPCOL = 1'b0,
    MAP_LINK_SPLIT   = 1'b1
  } pin_map_e;

  typedef struct packed {
    logic speed;
    logic aux;
    logic act;
  } led_vec_t;
endpackage

// File: rtl/led_rst_sync.sv
module led_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/led_blink_prescaler.sv
module led_blink_prescaler #(
  parameter int unsigned REF_HZ   = 25_000_000,
  parameter int unsigned BLINK_HZ = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave_fast,
  output logic wave_slow
);
  localparam int unsigned HALF = REF_HZ / (2 * BLINK_HZ);
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fast_q, fast_d, slow_q, slow_d;
  logic          wrap;

  always_comb begin
    wrap   = (cnt_q == LAST);
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    fast_d = wrap ? ~fast_q : fast_q;
    slow_d = (wrap && fast_q) ? ~slow_q : slow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fast_q <= fast_d;
      slow_q <= slow_d;
    end
  end

  assign wave_fast = fast_q;
  assign wave_slow = slow_q;
endmodule

// File: rtl/led_event_stretch.sv
module led_event_stretch #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic active
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] hold_q, hold_d;
  logic          hold_en;

  always_comb begin
    hold_en = evt || (hold_q != '0);
    hold_d  = evt ? LOAD : hold_q - 1'b1;
    active  = evt || (hold_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end
endmodule

// File: rtl/led_status_top.sv
module led_status_top #(
  parameter int unsigned REF_HZ   = 25_000_000,
  parameter int unsigned BLINK_HZ = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_mode,
  input  logic link_up,
  input  logic speed_100,
  input  logic full_dup,
  input  logic act_evt,
  input  logic coll_evt,
  output logic led_speed,
  output logic led_aux,
  output logic led_act
);
  import led_pkg::*;

  localparam int unsigned HALF     = REF_HZ / (2 * BLINK_HZ);
  localparam int unsigned ACT_HOLD = 4 * HALF;
  localparam int unsigned COL_HOLD = 2 * HALF;

  logic     rst_n_i;
  logic     wave_fast, wave_slow;
  logic     act_on, col_on;
  pin_map_e map_sel;
  led_vec_t led_d, led_q;

  led_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  led_blink_prescaler #(
    .REF_HZ   (REF_HZ),
    .BLINK_HZ (BLINK_HZ)
  ) u_presc (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wave_fast (wave_fast),
    .wave_slow (wave_slow)
  );

  led_event_stretch #(.HOLD(ACT_HOLD)) u_act_hold (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .evt    (act_evt),
    .active (act_on)
  );

  led_event_stretch #(.HOLD(COL_HOLD)) u_col_hold (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .evt    (coll_evt),
    .active (col_on)
  );

  always_comb begin
    map_sel     = pin_map_e'(pin_mode);
    led_d.speed = link_up && speed_100;
    led_d.act   = act_on && wave_slow;
    unique case (map_sel)
      MAP_SPEED_DUPCOL: led_d.aux = col_on ? wave_fast : (link_up && full_dup);
      MAP_LINK_SPLIT:   led_d.aux = link_up && !speed_100;
      default:          led_d.aux = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) led_q <= '0;
    else          led_q <= led_d;
  end

  assign led_speed = led_q.speed;
  assign led_aux   = led_q.aux;
  assign led_act   = led_q.act;
endmodule

// File: rtl/led_status_checker.sv
module led_status_checker #(
  parameter int unsigned REF_HZ   = 25_000_000,
  parameter int unsigned BLINK_HZ = 20
) (
  input logic clk,
  input logic rst_n,
  input logic pin_mode,
  input logic link_up,
  input logic speed_100,
  input logic full_dup,
  input logic act_evt,
  input logic coll_evt,
  input logic led_speed,
  input logic led_aux,
  input logic led_act
);
  localparam int unsigned HALF     = REF_HZ / (2 * BLINK_HZ);
  localparam int unsigned ACT_HOLD = 4 * HALF;
  localparam int unsigned COL_HOLD = 2 * HALF;
  localparam int unsigned IW       = $clog2(ACT_HOLD + 3);
  localparam logic [IW-1:0] IMAX   = IW'(ACT_HOLD + 2);

  logic [2:0]    age_q;
  logic [IW-1:0] act_idle_q, col_idle_q;
  logic          past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q      <= '0;
      act_idle_q <= IMAX;
      col_idle_q <= IMAX;
    end else begin
      if (age_q != 3'd4) age_q <= age_q + 3'd1;
      act_idle_q <= act_evt  ? '0 : ((act_idle_q == IMAX) ? IMAX : act_idle_q + 1'b1);
      col_idle_q <= coll_evt ? '0 : ((col_idle_q == IMAX) ? IMAX : col_idle_q + 1'b1);
    end
  end

  assign past_ok = (age_q >= 3'd4);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_DARK_IN_RESET: assert (!led_speed && !led_aux && !led_act); // R1
    end
  end

  AST_SPEED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (led_speed == $past(link_up && speed_100))); // R5

  AST_TEN_LINK_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(pin_mode) |-> (led_aux == $past(link_up && !speed_100))); // R8

  AST_ACT_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (act_idle_q > IW'(ACT_HOLD)) |-> !led_act); // R4

  AST_DUPLEX_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!pin_mode && link_up && full_dup && !coll_evt && (col_idle_q > IW'(COL_HOLD)))
    |-> led_aux); // R6
endmodule

bind led_status_top led_status_checker #(
  .REF_HZ   (REF_HZ),
  .BLINK_HZ (BLINK_HZ)
) u_chk (.*);

// File: tb/led_status_top_test.sv
module led_status_top_test;
  localparam int unsigned REF_HZ   = 80;
  localparam int unsigned BLINK_HZ = 10;
  localparam int HALF  = REF_HZ / (2 * BLINK_HZ);
  localparam int ALEN  = 4 * HALF;
  localparam int CLEN  = 2 * HALF;

  logic clk = 1'b0;
  logic rst_n, pin_mode, link_up, speed_100, full_dup, act_evt, coll_evt;
  logic led_speed, led_aux, led_act;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  led_status_top #(.REF_HZ(REF_HZ), .BLINK_HZ(BLINK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .link_up(link_up),
    .speed_100(speed_100), .full_dup(full_dup), .act_evt(act_evt),
    .coll_evt(coll_evt), .led_speed(led_speed), .led_aux(led_aux), .led_act(led_act)
  );

  // Behavioural reference: edge counting, event timestamps.
  int  p_edges;
  int  last_act, last_col;
  bit  e_spd, e_aux, e_act;
  string t_spd, t_aux, t_act;

  task automatic check1(input string tag, input logic got, input bit exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: got %b expected %b", tag, what, $time, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      p_edges = 0; last_act = -100000; last_col = -100000;
      e_spd = 0; e_aux = 0; e_act = 0;
      t_spd = "R1"; t_aux = "R1"; t_act = "R1";
    end else begin
      p_edges++;
      if (p_edges < 3) begin
        e_spd = 0; e_aux = 0; e_act = 0;
        t_spd = "R1"; t_aux = "R1"; t_act = "R1";
      end else begin
        int  n;
        bit  fw, sw, a_on, c_on;
        n    = p_edges - 3;
        fw   = ((n / HALF) % 2) == 1;
        sw   = ((n / (2 * HALF)) % 2) == 1;
        a_on = act_evt  || (n - last_act <= ALEN);
        c_on = coll_evt || (n - last_col <= CLEN);
        if (act_evt)  last_act = n;
        if (coll_evt) last_col = n;
        e_spd = link_up && speed_100;
        t_spd = pin_mode ? "R8" : "R5";
        e_act = a_on && sw;
        t_act = (a_on && !act_evt) ? "R4 R2" : "R3 R2";
        if (!pin_mode) begin
          e_aux = c_on ? fw : (link_up && full_dup);
          t_aux = c_on ? "R7 R2" : "R6";
        end else begin
          e_aux = link_up && !speed_100;
          t_aux = (c_on || full_dup) ? "R9" : "R8";
        end
      end
    end
    #5;
    check1(t_spd, led_speed, e_spd, "led_speed");
    check1(t_aux, led_aux,   e_aux, "led_aux");
    check1(t_act, led_act,   e_act, "led_act");
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_act();
    @(negedge clk); act_evt = 1'b1; @(negedge clk); act_evt = 1'b0;
  endtask

  task automatic pulse_col();
    @(negedge clk); coll_evt = 1'b1; @(negedge clk); coll_evt = 1'b0;
  endtask

  task automatic random_phase(input bit mode, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pin_mode = mode;
      act_evt  = ($urandom % 23) == 0;
      coll_evt = ($urandom % 31) == 0;
      if (($urandom % 97) == 0) link_up   = ~link_up;
      if (($urandom % 89) == 0) speed_100 = ~speed_100;
      if (($urandom % 83) == 0) full_dup  = ~full_dup;
    end
    @(negedge clk); act_evt = 0; coll_evt = 0;
  endtask

  initial begin
    rst_n = 0; pin_mode = 0; link_up = 0; speed_100 = 0; full_dup = 0;
    act_evt = 0; coll_evt = 0;
    idle(4);
    rst_n = 1;                                  // R1 window follows
    idle(6);
    link_up = 1; speed_100 = 1; full_dup = 1;   // R5 R6
    idle(40);
    pulse_act(); idle(30);                      // R3 R4 single burst
    pulse_act(); idle(5); pulse_act(); idle(40);// R4 retrigger
    pulse_col(); idle(20);                      // R7 over duplex
    full_dup = 0; pulse_col(); idle(20);        // R7 half duplex
    speed_100 = 0; idle(20);                    // R5 off at 10M
    link_up = 0; idle(10);
    pin_mode = 1; link_up = 1; speed_100 = 1; idle(10); // R8
    speed_100 = 0; full_dup = 1; pulse_col(); idle(20); // R9
    link_up = 0; pulse_col(); pulse_act(); idle(30);
    random_phase(1'b0, 1500);
    @(negedge clk); act_evt = 1; rst_n = 0;     // R1 mid-run
    idle(3); act_evt = 0; rst_n = 1;
    idle(10);
    random_phase(1'b1, 1000);
    random_phase(1'b0, 600);
    idle(40);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule